// File: doc/BRIEF.md
# Double-Buffered Serial Frame Sender

This block shifts fixed-length frames out on a single serial line. Each frame is taken from one of two equally sized word buffers, named A and B. Software fills either buffer through a 16-bit word write port. It then writes a control word that holds an enable bit, a buffer-select bit and an interrupt-enable bit. Bit timing comes from a one-cycle bit-clock enable, so the line rate is set by whoever drives that strobe.

While the enable bit is set, frames follow each other with no gap. The source buffer is never swapped by the hardware: each frame uses whatever select value is held in the control register at the moment that frame begins. Clearing the enable bit lets the frame in progress run to its last bit, and then the line drops to 0. At every frame end a sticky status flag is set. Software clears the flag by writing 1 to it. The interrupt line is that flag gated by the interrupt-enable bit. Buffer contents may be rewritten at any time, and no error of any kind is reported.

By default a frame is 40 words of 16 bits, which is 640 bits.

Top module: `tx_frame_sender`

## Requirements
- R1: After reset, `tx_sd`, `sts_flag` and `irq` are all 0.
- R2: Whenever no frame is in progress, `tx_sd` is 0.
- R3: A control write with `cfg_en`=1 starts a frame at the first `bit_ce` cycle after the write has been registered. That first bit is the MSB of word 0 of the buffer chosen by `cfg_sel` in the same write (0 = buffer A, 1 = buffer B).
- R4: A frame is FRAME_WORDS*WORD_W bits long. Within each word the bits go out MSB first, and the words go out in ascending address order. `tx_sd` changes only in cycles where `bit_ce` is 1.
- R5: While enabled, the next frame starts on the `bit_ce` right after the last bit of the current frame. Its source buffer is the select value held at that boundary. The hardware never switches buffers on its own.
- R6: Writing `cfg_en`=0 during a frame does not shorten that frame. After its last bit the line returns to 0, and no further frame starts.
- R7: `sts_flag` becomes 1 at the `bit_ce` that closes a frame, which is the one after its last bit. It then stays 1 until a `sts_clr` pulse clears it.
- R8: If a frame closes in the same cycle as a `sts_clr` pulse, the flag ends up set.
- R9: `irq` equals `sts_flag` AND the stored interrupt-enable bit.
- R10: Buffer writes are accepted at any time, including into the buffer being sent. A word rewritten before its turn goes out with its new value, and no error indication exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_en | input | 1 | Enable value written by `cfg_wr` |
| cfg_sel | input | 1 | Buffer select written by `cfg_wr` (0 = A, 1 = B) |
| cfg_ie | input | 1 | Interrupt enable written by `cfg_wr` |
| sts_clr | input | 1 | Write-1-to-clear pulse for the frame-done flag |
| sts_flag | output | 1 | Sticky frame-done flag |
| buf_wr | input | 1 | Buffer word write strobe |
| buf_sel | input | 1 | Buffer written (0 = A, 1 = B) |
| buf_addr | input | AW | Word address within the buffer |
| buf_wdata | input | WORD_W | Word written |
| bit_ce | input | 1 | Serial bit-clock enable, one cycle per bit |
| tx_sd | output | 1 | Serial data out |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with FRAME_WORDS = 4 and WORD_W = 16, which gives 64-bit frames and a 2-bit buffer address. With frames that short, one run can cover single frames from each buffer, a three-frame back-to-back chain with a select change at a boundary, and a disable that lands mid-frame. It can also cover a clear pulse placed exactly on the closing `bit_ce`, and a rewrite of the last word of the buffer while that buffer is being sent. All of this fits in a few thousand cycles. The word-boundary stepping and the end-of-frame counter compare are the same logic at the default size, so the small build exercises them as they are.

// File: rtl/txf_pkg.sv
package txf_pkg;
  localparam int NUM_BUFS = 2;

  typedef struct packed {
    logic en;
    logic sel;
    logic ie;
  } txf_ctrl_t;
endpackage

// File: rtl/txf_ctrl_regs.sv
module txf_ctrl_regs
  import txf_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfg_wr,
  input  logic      cfg_en,
  input  logic      cfg_sel,
  input  logic      cfg_ie,
  input  logic      sts_clr,
  input  logic      frame_done,
  output txf_ctrl_t ctrl,
  output logic      sts_flag,
  output logic      irq
);
  txf_ctrl_t ctrl_q, ctrl_d;
  logic      flag_q, flag_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (cfg_wr) begin
      ctrl_d.en  = cfg_en;
      ctrl_d.sel = cfg_sel;
      ctrl_d.ie  = cfg_ie;
    end
    // a frame end always wins over a clear in the same cycle
    flag_d = frame_done | (flag_q & ~sts_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      flag_q <= flag_d;
    end
  end

  assign ctrl     = ctrl_q;
  assign sts_flag = flag_q;
  assign irq      = flag_q & ctrl_q.ie;

  // R7 / R8: a closing frame sets the flag even under a clear
  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> sts_flag);
  // R7: the flag is sticky until cleared
  p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_flag && !sts_clr) |=> sts_flag);
  // R7: a clear with no frame end drops the flag
  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr && !frame_done) |=> !sts_flag);
endmodule

// File: rtl/txf_frame_store.sv
module txf_frame_store
  import txf_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int FRAME_WORDS = 40,
  localparam int AW = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              wr_buf,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_buf,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam logic [AW:0] ADDR_LIMIT = (AW+1)'(FRAME_WORDS);

  logic [WORD_W-1:0] rd_word [NUM_BUFS];
  logic              addr_ok;

  assign addr_ok = ({1'b0, wr_addr} < ADDR_LIMIT);

  for (genvar b = 0; b < NUM_BUFS; b++) begin : g_buf
    logic [WORD_W-1:0] mem [FRAME_WORDS];
    logic              we;

    assign we = wr_en && addr_ok && (wr_buf == b[0]);

    always_ff @(posedge clk) begin
      if (we) mem[wr_addr] <= wr_data;
    end

    assign rd_word[b] = mem[rd_addr];
  end

  assign rd_data = rd_word[rd_buf];
endmodule

// File: rtl/txf_serializer.sv
module txf_serializer #(
  parameter int WORD_W      = 16,
  parameter int FRAME_WORDS = 40,
  localparam int AW = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_ce,
  input  logic              en,
  input  logic              sel,
  input  logic [WORD_W-1:0] rd_data,
  output logic              rd_buf,
  output logic [AW-1:0]     rd_addr,
  output logic              tx_sd,
  output logic              frame_done
);
  localparam int FRAME_BITS = FRAME_WORDS * WORD_W;
  localparam int CW = $clog2(FRAME_BITS + 1);
  localparam int BW = $clog2(WORD_W);
  localparam logic [CW-1:0] LAST_CNT = CW'(FRAME_BITS);

  logic          active_q, active_d;
  logic          cur_sel_q, cur_sel_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          sd_q, sd_d;
  logic          at_end, start_frame;
  logic [CW-1:0] fetch_idx;
  logic [BW-1:0] bit_pos;

  // cnt_q counts bits already placed on the line in this frame
  assign at_end      = active_q && (cnt_q == LAST_CNT);
  assign start_frame = bit_ce && en && (!active_q || at_end);
  assign frame_done  = bit_ce && at_end;

  assign fetch_idx = start_frame ? '0 : cnt_q;
  assign rd_buf    = start_frame ? sel : cur_sel_q;
  assign rd_addr   = AW'(fetch_idx >> BW);
  assign bit_pos   = ~fetch_idx[BW-1:0];

  always_comb begin
    active_d  = active_q;
    cur_sel_d = cur_sel_q;
    cnt_d     = cnt_q;
    sd_d      = sd_q;
    if (bit_ce) begin
      if (start_frame) begin
        active_d  = 1'b1;
        cur_sel_d = sel;
        cnt_d     = CW'(1);
        sd_d      = rd_data[bit_pos];
      end else if (at_end || !active_q) begin
        active_d = 1'b0;
        cnt_d    = '0;
        sd_d     = 1'b0;
      end else begin
        cnt_d = cnt_q + CW'(1);
        sd_d  = rd_data[bit_pos];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      cur_sel_q <= 1'b0;
      cnt_q     <= '0;
      sd_q      <= 1'b0;
    end else begin
      active_q  <= active_d;
      cur_sel_q <= cur_sel_d;
      cnt_q     <= cnt_d;
      sd_q      <= sd_d;
    end
  end

  assign tx_sd = sd_q;

  // R4: the bit counter never passes the frame length
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_CNT);
  // R4: the line only moves on a bit-clock cycle
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_ce |=> $stable(tx_sd));
  // R2: idle line is low
  p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> !tx_sd);
  // R6: a disabled sender stops at the frame boundary
  p_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !en) |=> !active_q);
  // R5: the source buffer is fixed for the whole frame
  p_sel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !frame_done) |=> $stable(cur_sel_q));
endmodule

// File: rtl/tx_frame_sender.sv
module tx_frame_sender
  import txf_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int FRAME_WORDS = 40,
  localparam int AW = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_en,
  input  logic              cfg_sel,
  input  logic              cfg_ie,
  input  logic              sts_clr,
  output logic              sts_flag,
  input  logic              buf_wr,
  input  logic              buf_sel,
  input  logic [AW-1:0]     buf_addr,
  input  logic [WORD_W-1:0] buf_wdata,
  input  logic              bit_ce,
  output logic              tx_sd,
  output logic              irq
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  txf_ctrl_t         ctrl;
  logic              frame_done;
  logic              rd_buf;
  logic [AW-1:0]     rd_addr;
  logic [WORD_W-1:0] rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  txf_ctrl_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .cfg_wr     (cfg_wr),
    .cfg_en     (cfg_en),
    .cfg_sel    (cfg_sel),
    .cfg_ie     (cfg_ie),
    .sts_clr    (sts_clr),
    .frame_done (frame_done),
    .ctrl       (ctrl),
    .sts_flag   (sts_flag),
    .irq        (irq)
  );

  txf_frame_store #(.WORD_W(WORD_W), .FRAME_WORDS(FRAME_WORDS)) u_store (
    .clk     (clk),
    .wr_en   (buf_wr),
    .wr_buf  (buf_sel),
    .wr_addr (buf_addr),
    .wr_data (buf_wdata),
    .rd_buf  (rd_buf),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  txf_serializer #(.WORD_W(WORD_W), .FRAME_WORDS(FRAME_WORDS)) u_ser (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .bit_ce     (bit_ce),
    .en         (ctrl.en),
    .sel        (ctrl.sel),
    .rd_data    (rd_data),
    .rd_buf     (rd_buf),
    .rd_addr    (rd_addr),
    .tx_sd      (tx_sd),
    .frame_done (frame_done)
  );
endmodule

// File: tb/tb_tx_frame_sender.sv
`timescale 1ns/1ps
module tb_tx_frame_sender;
  localparam int WW = 16;
  localparam int FW = 4;
  localparam int AW = 2;
  localparam int FB = FW * WW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_wr, cfg_en, cfg_sel, cfg_ie, sts_clr;
  logic          sts_flag, irq, tx_sd;
  logic          buf_wr, buf_sel;
  logic [AW-1:0] buf_addr;
  logic [WW-1:0] buf_wdata;
  logic          bit_ce;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [WW-1:0] mdl [2][FW];
  logic [1:0]    exp_q[$];   // {first bit of frame, expected bit}

  always #2.5 clk = ~clk;

  tx_frame_sender #(.WORD_W(WW), .FRAME_WORDS(FW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
    .cfg_sel(cfg_sel), .cfg_ie(cfg_ie), .sts_clr(sts_clr),
    .sts_flag(sts_flag), .buf_wr(buf_wr), .buf_sel(buf_sel),
    .buf_addr(buf_addr), .buf_wdata(buf_wdata), .bit_ce(bit_ce),
    .tx_sd(tx_sd), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // bit clock: one enable cycle in every four
  initial begin
    bit_ce = 1'b0;
    forever begin
      @(negedge clk) bit_ce = 1'b1;
      @(negedge clk) bit_ce = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
  end

  // monitor / scoreboard
  logic [1:0] item;
  logic       last_sd = 1'b0;
  string      tag;
  initial begin
    forever begin
      @(posedge clk);
      if (bit_ce) begin
        if (exp_q.size() > 0) begin
          item = exp_q.pop_front();
          tag  = item[1] ? "R3 first bit of frame" : "R4 frame bit";
        end else begin
          item = 2'b00;
          tag  = "R2 idle line";
        end
        @(negedge clk);
        chk(tx_sd === item[0], tag, {31'd0, tx_sd}, {31'd0, item[0]});
        last_sd = tx_sd;
      end else begin
        @(negedge clk);
        if (rst_n) chk(tx_sd === last_sd, "R4 hold between bit cycles",
                       {31'd0, tx_sd}, {31'd0, last_sd});
      end
    end
  end

  task automatic push_frame(input int s);
    for (int w = 0; w < FW; w++)
      for (int b = WW - 1; b >= 0; b--)
        exp_q.push_back({(w == 0 && b == WW - 1), mdl[s][w][b]});
  endtask

  task automatic buf_write(input int s, input int a, input logic [WW-1:0] d);
    mdl[s][a] = d;
    buf_wr = 1'b1; buf_sel = s[0]; buf_addr = AW'(a); buf_wdata = d;
    @(negedge clk);
    buf_wr = 1'b0;
  endtask

  task automatic cfg_write(input bit en, input bit sel, input bit ie);
    cfg_wr = 1'b1; cfg_en = en; cfg_sel = sel; cfg_ie = ie;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic clr_pulse();
    sts_clr = 1'b1;
    @(negedge clk);
    sts_clr = 1'b0;
  endtask

  task automatic sync_bit();
    do @(posedge clk); while (!bit_ce);
    @(negedge clk);
  endtask

  task automatic wait_bits(input int n);
    for (int i = 0; i < n; i++) sync_bit();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 0; cfg_en = 0; cfg_sel = 0; cfg_ie = 0;
    sts_clr = 0; buf_wr = 0; buf_sel = 0; buf_addr = '0; buf_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    chk(tx_sd === 1'b0, "R1 tx_sd after reset", {31'd0, tx_sd}, 0);
    chk(sts_flag === 1'b0, "R1 flag after reset", {31'd0, sts_flag}, 0);
    chk(irq === 1'b0, "R1 irq after reset", {31'd0, irq}, 0);

    for (int i = 0; i < FW; i++) begin
      buf_write(0, i, 16'h8001 ^ WW'(i * 16'h0F35));
      buf_write(1, i, 16'h7E00 + WW'(i * 16'h0123));
    end
    wait_bits(3);

    // single frame from A, interrupt disabled (R3 R4 R7 R9)
    sync_bit();
    push_frame(0);
    cfg_write(1, 0, 0);
    sync_bit();
    cfg_write(0, 0, 0);
    wait_bits(FB - 1);
    chk(sts_flag === 1'b0, "R7 flag low during last bit", {31'd0, sts_flag}, 0);
    wait_bits(1);
    chk(sts_flag === 1'b1, "R7 flag set at frame close", {31'd0, sts_flag}, 1);
    chk(irq === 1'b0, "R9 irq masked", {31'd0, irq}, 0);
    cfg_write(0, 0, 1);
    chk(irq === 1'b1, "R9 irq after enable", {31'd0, irq}, 1);
    wait_bits(5);
    chk(sts_flag === 1'b1, "R7 flag sticky", {31'd0, sts_flag}, 1);
    clr_pulse();
    chk(sts_flag === 1'b0, "R7 flag cleared", {31'd0, sts_flag}, 0);
    chk(irq === 1'b0, "R9 irq follows clear", {31'd0, irq}, 0);

    // single frame from B, clear on the closing bit cycle (R3 R8)
    sync_bit();
    push_frame(1);
    cfg_write(1, 1, 1);
    sync_bit();
    cfg_write(0, 1, 1);
    wait_bits(FB - 1);
    repeat (3) @(negedge clk);
    sts_clr = 1'b1;
    @(negedge clk);
    sts_clr = 1'b0;
    chk(sts_flag === 1'b1, "R8 set wins over clear", {31'd0, sts_flag}, 1);
    chk(irq === 1'b1, "R9 irq with flag and enable", {31'd0, irq}, 1);
    clr_pulse();
    chk(sts_flag === 1'b0, "R7 clear after R8 case", {31'd0, sts_flag}, 0);

    // back-to-back chain A,B,B then disable mid-frame (R5 R6)
    sync_bit();
    push_frame(0);
    cfg_write(1, 0, 1);
    sync_bit();
    cfg_write(1, 1, 1);
    push_frame(1);
    wait_bits(FB);
    push_frame(1);
    wait_bits(FB);
    cfg_write(0, 1, 1);
    wait_bits(FB + 8);
    chk(exp_q.size() == 0, "R6 chain drained, no extra frame",
        exp_q.size(), 0);
    chk(sts_flag === 1'b1, "R7 flag after chain", {31'd0, sts_flag}, 1);
    clr_pulse();

    // rewrite last word of the buffer being sent (R10)
    sync_bit();
    mdl[0][FW-1] = 16'h5AC3;
    push_frame(0);
    cfg_write(1, 0, 1);
    sync_bit();
    buf_write(0, FW - 1, 16'h5AC3);
    cfg_write(0, 0, 1);
    wait_bits(FB + 4);
    chk(sts_flag === 1'b1, "R10 frame completes normally",
        {31'd0, sts_flag}, 1);
    chk(exp_q.size() == 0, "R10 all bits seen", exp_q.size(), 0);

    finish_run();
  end
endmodule